// File: doc/BRIEF.md
# Endpoint List Service Scheduler

This block picks, one descriptor at a time, which endpoint-descriptor list a USB host controller works on next inside a frame. A frame opens with the start-of-frame strobe. The scheduler first serves the periodic list for as long as that list is enabled, not exhausted, and not stopped at an isochronous descriptor while isochronous work is switched off. After that it interleaves control and bulk descriptors. A two-bit ratio sets how many nonempty control descriptors are served for each bulk descriptor.

Each choice appears on a two-bit select together with a one-cycle grant. The descriptor engine answers with a done strobe. A qualifier on that strobe says whether the descriptor actually carried work, and only such control descriptors advance the ratio count. The count survives frame boundaries. The four list-enable inputs are copied into shadow registers on each start-of-frame strobe, so a software change to them takes effect in the following frame. When neither nonperiodic list can be served, the scheduler parks on idle until the next frame.

Top module: `edlist_sched`

## Requirements
- R1: After reset, select is idle (code 0), grant is low and the ratio count is zero. No selection is made until the first start-of-frame strobe.
- R2: Select codes are idle=0, periodic=1, control=2, bulk=3. With ratio value r (00→1:1, 01→2:1, 10→3:1, 11→4:1), control is chosen while the count is at most r. When all descriptors are nonempty, this gives r+1 control grants per bulk grant.
- R3: A done strobe on a control descriptor increments the count only when the nonempty qualifier is high. An empty control descriptor leaves the count unchanged.
- R4: The count is not cleared by a start-of-frame strobe. A new frame continues the control/bulk pattern where the previous frame stopped.
- R5: The enable inputs for periodic, control, bulk and isochronous work are sampled only on a start-of-frame strobe. Changes made between strobes do not affect any choice in the current frame.
- R6: After a start-of-frame strobe, the periodic list is chosen while its shadow enable is set and it is not empty. Once the scheduler leaves periodic work, it does not return to periodic work in that frame.
- R7: If the current periodic descriptor is isochronous and isochronous work is disabled in the shadow, periodic work ends and the scheduler moves to control/bulk. If isochronous work is enabled, periodic work continues.
- R8: If the list the ratio asks for is disabled or empty, the other nonperiodic list is chosen when it is enabled and nonempty.
- R9: If neither nonperiodic list can be served, select goes idle with no grant and stays idle until the next start-of-frame strobe, even if the lists become available.
- R10: A done strobe on a bulk descriptor clears the count to zero.
- R11: The grant is high for exactly one cycle, one cycle after the strobe that triggers the decision. Select then holds its value while the descriptor is in progress.
- R12: A start-of-frame strobe restarts the frame even while a descriptor is outstanding. The abandoned descriptor does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| sof | input | 1 | Start-of-frame strobe |
| en_per | input | 1 | Periodic list enable (applies from next frame) |
| en_ctl | input | 1 | Control list enable (applies from next frame) |
| en_blk | input | 1 | Bulk list enable (applies from next frame) |
| en_iso | input | 1 | Isochronous descriptor enable (applies from next frame) |
| ratio | input | RATIO_W | Control-to-bulk service ratio minus one |
| per_empty | input | 1 | No further periodic descriptor this frame |
| ctl_empty | input | 1 | Control list has no descriptor |
| blk_empty | input | 1 | Bulk list has no descriptor |
| iso_hit | input | 1 | Next periodic descriptor is isochronous |
| ed_done | input | 1 | Descriptor service finished |
| ed_nonempty | input | 1 | Finished descriptor carried a transfer |
| sel | output | 2 | Selected list: 0 idle, 1 periodic, 2 control, 3 bulk |
| grant | output | 1 | One-cycle strobe marking a new selection |

## Verification
The hardest case to reach is a count carried over a frame boundary. The count is a value from inside the block, and it only shows up later, as the position of the next bulk grant. To get there, the stimulus serves one nonempty control descriptor at a 2:1 ratio. It then empties both lists so the frame ends in idle, restores the lists, and issues a new strobe. The next frame must give exactly one control grant before the bulk grant. The mid-frame enable changes and the isochronous stop are reached in a similar way: inputs are changed between the grant and the done strobe, and the choice that follows shows whether the shadow copy was used.

// File: rtl/edsched_pkg.sv
package edsched_pkg;

   typedef enum logic [1:0] {
      SEL_IDLE = 2'd0,
      SEL_PER  = 2'd1,
      SEL_CTL  = 2'd2,
      SEL_BLK  = 2'd3
   } sel_t;

   typedef enum logic [1:0] {
      ST_WAIT   = 2'd0,
      ST_DECIDE = 2'd1,
      ST_BUSY   = 2'd2
   } fsm_t;

   // positions inside the enable vector
   localparam int EN_PER = 0;
   localparam int EN_CTL = 1;
   localparam int EN_BLK = 2;
   localparam int EN_ISO = 3;
   localparam int N_EN   = 4;

endpackage

// File: rtl/edsched_shadow.sv
module edsched_shadow #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   initial begin
      if (N < 1) $error("edsched_shadow: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)    q[i] <= 1'b0;
         else if (load) q[i] <= d[i];
      end
   end

endmodule

// File: rtl/edsched_ratio.sv
module edsched_ratio #(
   parameter int RATIO_W = 2,
   localparam int CNT_W  = RATIO_W + 1,
   localparam int CNT_MAX = 1 << RATIO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               inc,
   input  logic               clr,
   output logic [CNT_W-1:0]   cnt,
   output logic               want_ctl
);

   logic [CNT_W-1:0] ratio_x;
   logic             at_max;

   assign ratio_x  = {1'b0, ratio};
   assign at_max   = (cnt == CNT_W'(CNT_MAX));
   assign want_ctl = (cnt <= ratio_x);

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (clr)             cnt <= '0;
      else if (inc && !at_max)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/edsched_arb.sv
module edsched_arb
   import edsched_pkg::*;
(
   input  logic in_per,
   input  logic sh_per,
   input  logic sh_ctl,
   input  logic sh_blk,
   input  logic sh_iso,
   input  logic per_empty,
   input  logic iso_hit,
   input  logic ctl_empty,
   input  logic blk_empty,
   input  logic want_ctl,
   output sel_t pick
);

   logic per_ok, ctl_ok, blk_ok;

   assign per_ok = in_per && sh_per && !per_empty && !(iso_hit && !sh_iso);
   assign ctl_ok = sh_ctl && !ctl_empty;
   assign blk_ok = sh_blk && !blk_empty;

   always_comb begin
      pick = SEL_IDLE;
      if (per_ok) begin
         pick = SEL_PER;
      end else if (want_ctl) begin
         if (ctl_ok)      pick = SEL_CTL;
         else if (blk_ok) pick = SEL_BLK;
      end else begin
         if (blk_ok)      pick = SEL_BLK;
         else if (ctl_ok) pick = SEL_CTL;
      end
   end

endmodule

// File: rtl/edlist_sched.sv
module edlist_sched
   import edsched_pkg::*;
#(
   parameter int RATIO_W = 2,
   localparam int CNT_W  = RATIO_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sof,
   input  logic               en_per,
   input  logic               en_ctl,
   input  logic               en_blk,
   input  logic               en_iso,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               per_empty,
   input  logic               ctl_empty,
   input  logic               blk_empty,
   input  logic               iso_hit,
   input  logic               ed_done,
   input  logic               ed_nonempty,
   output logic [1:0]         sel,
   output logic               grant
);

   if (RATIO_W < 1 || RATIO_W > 4) begin : g_bad_ratio_w
      $error("edlist_sched: RATIO_W out of range 1..4");
   end

   logic [N_EN-1:0]  en_live;
   logic [N_EN-1:0]  sh_en;
   logic [CNT_W-1:0] cnt_q;
   logic             want_ctl;
   logic             busy;
   logic             done_ok;
   logic             cnt_inc;
   logic             cnt_clr;
   logic             in_per;
   fsm_t             state;
   sel_t             sel_q;
   sel_t             pick;

   always_comb begin
      en_live         = '0;
      en_live[EN_PER] = en_per;
      en_live[EN_CTL] = en_ctl;
      en_live[EN_BLK] = en_blk;
      en_live[EN_ISO] = en_iso;
   end

   edsched_shadow #(.N(N_EN)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sof),
      .d     (en_live),
      .q     (sh_en)
   );

   assign busy    = (state == ST_BUSY);
   assign done_ok = busy && ed_done && !sof;
   assign cnt_inc = done_ok && (sel_q == SEL_CTL) && ed_nonempty;
   assign cnt_clr = done_ok && (sel_q == SEL_BLK);

   edsched_ratio #(.RATIO_W(RATIO_W)) u_ratio (
      .clk      (clk),
      .rst_n    (rst_n),
      .ratio    (ratio),
      .inc      (cnt_inc),
      .clr      (cnt_clr),
      .cnt      (cnt_q),
      .want_ctl (want_ctl)
   );

   edsched_arb u_arb (
      .in_per    (in_per),
      .sh_per    (sh_en[EN_PER]),
      .sh_ctl    (sh_en[EN_CTL]),
      .sh_blk    (sh_en[EN_BLK]),
      .sh_iso    (sh_en[EN_ISO]),
      .per_empty (per_empty),
      .iso_hit   (iso_hit),
      .ctl_empty (ctl_empty),
      .blk_empty (blk_empty),
      .want_ctl  (want_ctl),
      .pick      (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_WAIT;
         sel_q  <= SEL_IDLE;
         grant  <= 1'b0;
         in_per <= 1'b0;
      end else if (sof) begin
         state  <= ST_DECIDE;
         sel_q  <= SEL_IDLE;
         grant  <= 1'b0;
         in_per <= 1'b1;
      end else begin
         case (state)
            ST_DECIDE: begin
               sel_q  <= pick;
               grant  <= (pick != SEL_IDLE);
               in_per <= (pick == SEL_PER);
               state  <= (pick == SEL_IDLE) ? ST_WAIT : ST_BUSY;
            end
            ST_BUSY: begin
               grant <= 1'b0;
               if (ed_done) state <= ST_DECIDE;
            end
            default: begin
               grant <= 1'b0;
            end
         endcase
      end
   end

   assign sel = sel_q;

endmodule

// File: rtl/edlist_sched_chk.sv
module edlist_sched_chk
   import edsched_pkg::*;
#(
   parameter int RATIO_W = 2,
   localparam int CNT_W  = RATIO_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sof,
   input logic             ed_done,
   input logic             ed_nonempty,
   input logic [1:0]       sel,
   input logic             grant,
   input logic             busy,
   input logic [CNT_W-1:0] cnt,
   input logic [N_EN-1:0]  sh_en
);

   a_r11_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> !grant);

   a_r11_grant_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (sel != SEL_IDLE));

   a_r5_ctl_shadowed: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && sel == SEL_CTL) |-> sh_en[EN_CTL]);

   a_r5_blk_shadowed: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && sel == SEL_BLK) |-> sh_en[EN_BLK]);

   a_r6_per_shadowed: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && sel == SEL_PER) |-> sh_en[EN_PER]);

   a_r10_bulk_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ed_done && !sof && sel == SEL_BLK) |=> (cnt == '0));

   a_r3_empty_ctl_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ed_done && !sof && sel == SEL_CTL && !ed_nonempty) |=> $stable(cnt));

   a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(1 << RATIO_W));

   a_r12_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (!grant && !busy));

endmodule

bind edlist_sched edlist_sched_chk #(.RATIO_W(RATIO_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sof         (sof),
   .ed_done     (ed_done),
   .ed_nonempty (ed_nonempty),
   .sel         (sel),
   .grant       (grant),
   .busy        (busy),
   .cnt         (cnt_q),
   .sh_en       (sh_en)
);

// File: tb/edlist_sched_tb.sv
module edlist_sched_tb;

   localparam logic [1:0] S_IDLE = 2'd0;
   localparam logic [1:0] S_PER  = 2'd1;
   localparam logic [1:0] S_CTL  = 2'd2;
   localparam logic [1:0] S_BLK  = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sof = 1'b0;
   logic en_per = 1'b0, en_ctl = 1'b0, en_blk = 1'b0, en_iso = 1'b0;
   logic [1:0] ratio = 2'd0;
   logic per_empty = 1'b0, ctl_empty = 1'b0, blk_empty = 1'b0, iso_hit = 1'b0;
   logic ed_done = 1'b0, ed_nonempty = 1'b0;
   logic [1:0] sel;
   logic grant;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   edlist_sched #(.RATIO_W(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sof(sof),
      .en_per(en_per), .en_ctl(en_ctl), .en_blk(en_blk), .en_iso(en_iso),
      .ratio(ratio), .per_empty(per_empty), .ctl_empty(ctl_empty),
      .blk_empty(blk_empty), .iso_hit(iso_hit),
      .ed_done(ed_done), .ed_nonempty(ed_nonempty),
      .sel(sel), .grant(grant)
   );

   task automatic check_out(input logic [1:0] exp_sel, input logic exp_grant,
                            input string tag);
      checks++;
      if (sel !== exp_sel || grant !== exp_grant) begin
         errors++;
         $display("FAIL %s: sel=%0d grant=%0d expected sel=%0d grant=%0d",
                  tag, sel, grant, exp_sel, exp_grant);
      end
   endtask

   // next negedge must show a fresh grant on exp
   task automatic expect_grant(input logic [1:0] exp, input string tag);
      @(negedge clk);
      check_out(exp, 1'b1, tag);
   endtask

   task automatic expect_idle(input string tag);
      @(negedge clk);
      check_out(S_IDLE, 1'b0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sof = 0; ed_done = 0; ed_nonempty = 0;
      per_empty = 0; ctl_empty = 0; blk_empty = 0; iso_hit = 0;
      en_per = 0; en_ctl = 0; en_blk = 0; en_iso = 0; ratio = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse_sof();
      @(negedge clk);
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
   endtask

   task automatic finish_ed(input logic ne);
      @(negedge clk);
      ed_done = 1'b1;
      ed_nonempty = ne;
      @(negedge clk);
      ed_done = 1'b0;
      ed_nonempty = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      en_ctl = 1; en_blk = 1;
      for (int i = 0; i < 4; i++) expect_idle("R1 reset idle, no SOF yet");
   endtask

   task automatic t_ratio(input logic [1:0] r);
      do_reset();
      en_ctl = 1; en_blk = 1; ratio = r;
      pulse_sof();
      for (int round = 0; round < 2; round++) begin
         for (int k = 0; k <= int'(r); k++) begin
            expect_grant(S_CTL, $sformatf("R2 ratio %0d control slot %0d", r, k));
            finish_ed(1'b1);
         end
         expect_grant(S_BLK, $sformatf("R2 ratio %0d bulk slot", r));
         finish_ed(1'b1);
      end
   endtask

   task automatic t_empty_ctl();
      do_reset();
      en_ctl = 1; en_blk = 1; ratio = 2'd0;
      pulse_sof();
      expect_grant(S_CTL, "R3 first control");
      finish_ed(1'b0);
      expect_grant(S_CTL, "R3 empty control not counted");
      finish_ed(1'b1);
      expect_grant(S_BLK, "R3 nonempty control counted");
      finish_ed(1'b1);
      expect_grant(S_CTL, "R10 bulk cleared count");
   endtask

   task automatic t_persist();
      do_reset();
      en_ctl = 1; en_blk = 1; ratio = 2'd1;
      pulse_sof();
      expect_grant(S_CTL, "R4 frame1 control");
      ctl_empty = 1; blk_empty = 1;
      finish_ed(1'b1);
      expect_idle("R9 both lists empty");
      ctl_empty = 0; blk_empty = 0;
      for (int i = 0; i < 4; i++) expect_idle("R9 idle holds until SOF");
      pulse_sof();
      expect_grant(S_CTL, "R4 frame2 control continues count");
      finish_ed(1'b1);
      expect_grant(S_BLK, "R4 bulk after carried count");
   endtask

   task automatic t_shadow();
      do_reset();
      en_ctl = 1; en_blk = 1; ratio = 2'd3;
      pulse_sof();
      expect_grant(S_CTL, "R5 control in frame");
      en_ctl = 0;
      finish_ed(1'b1);
      expect_grant(S_CTL, "R5 live disable ignored mid-frame");
      pulse_sof();
      expect_grant(S_BLK, "R8 control disabled from next frame");
      // bulk enabled mid-frame is not seen
      do_reset();
      en_ctl = 1; en_blk = 0; ratio = 2'd0;
      pulse_sof();
      expect_grant(S_CTL, "R5 control only");
      en_blk = 1;
      finish_ed(1'b1);
      expect_grant(S_CTL, "R8 bulk wanted but shadow off, fall to control");
      pulse_sof();
      expect_grant(S_BLK, "R5 bulk enable applies next frame");
   endtask

   task automatic t_periodic();
      do_reset();
      en_per = 1; en_iso = 0; en_ctl = 1; en_blk = 1; ratio = 2'd0;
      pulse_sof();
      expect_grant(S_PER, "R6 periodic first");
      @(negedge clk);
      check_out(S_PER, 1'b0, "R11 grant one cycle, select held");
      finish_ed(1'b1);
      expect_grant(S_PER, "R6 periodic continues");
      iso_hit = 1;
      finish_ed(1'b1);
      expect_grant(S_CTL, "R7 iso disabled stops periodic");
      iso_hit = 0;
      finish_ed(1'b1);
      expect_grant(S_BLK, "R6 no return to periodic");
      finish_ed(1'b1);
      en_iso = 1;
      pulse_sof();
      expect_grant(S_PER, "R6 periodic in new frame");
      iso_hit = 1;
      finish_ed(1'b1);
      expect_grant(S_PER, "R7 iso enabled continues periodic");
      iso_hit = 0; per_empty = 1;
      finish_ed(1'b1);
      expect_grant(S_CTL, "R6 periodic exhausted");
      per_empty = 0;
      finish_ed(1'b1);
      expect_grant(S_BLK, "R6 periodic not resumed");
   endtask

   task automatic t_fallthrough();
      do_reset();
      en_ctl = 1; en_blk = 1; ratio = 2'd0; ctl_empty = 1;
      pulse_sof();
      expect_grant(S_BLK, "R8 control empty, bulk served");
      ctl_empty = 0; blk_empty = 1;
      finish_ed(1'b1);
      expect_grant(S_CTL, "R8 control after bulk");
      finish_ed(1'b1);
      expect_grant(S_CTL, "R8 bulk empty, control served");
   endtask

   task automatic t_sof_abort();
      do_reset();
      en_ctl = 1; en_blk = 1; ratio = 2'd0;
      pulse_sof();
      expect_grant(S_CTL, "R12 first control");
      pulse_sof();
      expect_grant(S_CTL, "R12 restart keeps count");
      finish_ed(1'b1);
      expect_grant(S_BLK, "R12 bulk after completed control");
   endtask

   initial begin
      t_reset();
      for (int r = 0; r < 4; r++) t_ratio(2'(r));
      t_empty_ctl();
      t_persist();
      t_shadow();
      t_periodic();
      t_fallthrough();
      t_sof_abort();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule